// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block holds the program counter of a 32-bit RISC core and works out where the next instruction comes from. Each cycle it looks at the current instruction word, the values of the first and second source registers, and the current PC. From these it forms the sequential address, a taken-branch address or a jump address. The result appears combinationally on `next_pc`. It is loaded into the PC register on a clock edge where `advance` is high.

Ten compare-and-branch conditions are supported: equality, inequality, and the signed and unsigned forms of the four ordering tests. A direct jump uses a 26-bit word offset. A register jump takes its target from the first operand. The two linking jumps also request a write of the return address (PC+4) into the link register. An external exception request overrides all of this: it loads a supplied vector and suppresses the link write. The register file, fetch and vector generation sit outside the block. All pins are plain control or data pins, sampled every cycle, and none of them carries a handshake.

Top module: `branch_npc`

## Requirements
- R1: Instruction fields are taken from fixed positions: opcode in bits 31:26, 16-bit branch immediate in bits 15:0, 26-bit jump offset in bits 25:0.
- R2: After reset `pc_q` equals the parameter RESET_PC (default 0), and `link_we` is low while `advance` is low.
- R3: `pc_q` takes the value of `next_pc` on a rising clock edge where `advance` is high, and holds its value otherwise.
- R4: Any opcode outside 0x20..0x2D gives `next_pc` = `pc_q`+4 with `link_we` low.
- R5: Opcodes 0x20..0x29 are branches. When the condition holds, `next_pc` = `pc_q`+4 + (sign-extended imm16 << 2). When it fails, `next_pc` = `pc_q`+4.
- R6: Branch conditions compare `opa` against `opb` in opcode order 0x20..0x29: equal, not equal, signed <=, unsigned <=, signed <, unsigned <, signed >=, unsigned >=, signed >, unsigned >.
- R7: Opcode 0x2A (jump) and 0x2C (jump-and-link) give `next_pc` = `pc_q`+4 + (sign-extended offset26 << 2).
- R8: Opcode 0x2B (register jump) and 0x2D (register jump-and-link) give `next_pc` = `opa` unchanged, including its two low bits.
- R9: Opcodes 0x2C and 0x2D raise `link_we` while `advance` is high. In that case `link_data` = `pc_q`+4 and `link_idx` = 31.
- R10: For opcode 0x2D the target is the `opa` value presented in that cycle, even when the instruction names register 31 as its first source. The link write at the same edge does not alter the target.
- R11: While `exc_take` is high, `next_pc` = `exc_vector` and `link_we` is low, whatever the opcode.
- R12: `link_we` is never high while `advance` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Load `next_pc` into the PC this edge |
| instr | input | 32 | Current instruction word |
| opa | input | 32 | Value of the first source register |
| opb | input | 32 | Value of the second source register |
| exc_take | input | 1 | Exception override request |
| exc_vector | input | 32 | Address loaded when the override is active |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Combinational next program counter |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index (31) |
| link_data | output | 32 | Return address to be linked |

## Verification
The assertions hold on every cycle for the structural behaviour of the block:
- the PC holds without `advance`;
- the override loads the vector and never links;
- link writes require `advance`;
- register jumps pass `opa` through;
- the linking opcodes raise `link_we`.

Only the bench's scenarios can show the arithmetic. It checks each of the ten comparisons at signed/unsigned boundaries and with equal operands. It also checks negative and extreme offset sign extension, and the register-31 target case of the linking register jump. These are compared against an independent reference over a long random instruction stream.

// File: rtl/branch_npc_pkg.sv
package branch_npc_pkg;

  localparam logic [5:0] OPC_BR_FIRST = 6'h20;
  localparam logic [5:0] OPC_BR_LAST  = 6'h29;
  localparam logic [5:0] OPC_JMP      = 6'h2A;
  localparam logic [5:0] OPC_JREG     = 6'h2B;
  localparam logic [5:0] OPC_JLNK     = 6'h2C;
  localparam logic [5:0] OPC_JRLNK    = 6'h2D;

  localparam int NUM_COND = 10;
  localparam int COND_W   = 4;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_BR   = 2'd1,
    SRC_OFS  = 2'd2,
    SRC_REG  = 2'd3
  } tgt_src_e;

  typedef struct packed {
    logic              is_branch;
    logic [COND_W-1:0] cond;
    tgt_src_e          src;
    logic              link;
  } ctl_t;

endpackage

// File: rtl/branch_npc_decode.sv
module branch_npc_decode
  import branch_npc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctl_t       ctl
);

  logic [5:0] br_rel;

  assign br_rel = opcode - OPC_BR_FIRST;

  always_comb begin
    ctl.is_branch = 1'b0;
    ctl.cond      = '0;
    ctl.src       = SRC_SEQ;
    ctl.link      = 1'b0;
    if (opcode >= OPC_BR_FIRST && opcode <= OPC_BR_LAST) begin
      ctl.is_branch = 1'b1;
      ctl.cond      = br_rel[COND_W-1:0];
      ctl.src       = SRC_BR;
    end else begin
      case (opcode)
        OPC_JMP:   ctl.src = SRC_OFS;
        OPC_JREG:  ctl.src = SRC_REG;
        OPC_JLNK:  begin ctl.src = SRC_OFS; ctl.link = 1'b1; end
        OPC_JRLNK: begin ctl.src = SRC_REG; ctl.link = 1'b1; end
        default:   ctl.src = SRC_SEQ;
      endcase
    end
  end

endmodule

// File: rtl/branch_npc_cond.sv
module branch_npc_cond
  import branch_npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic [COND_W-1:0] cond,
  output logic              hit
);

  logic eq, lt_s, lt_u;
  logic [NUM_COND-1:0] flags;

  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  // Pairs of (signed, unsigned) orderings share one shape
  logic [1:0] lt_pair;
  assign lt_pair = {lt_u, lt_s};

  assign flags[0] = eq;
  assign flags[1] = !eq;

  for (genvar k = 0; k < 2; k++) begin : g_order
    assign flags[2 + k] = lt_pair[k] | eq;      // <=
    assign flags[4 + k] = lt_pair[k];           // <
    assign flags[6 + k] = !lt_pair[k];          // >=
    assign flags[8 + k] = !lt_pair[k] & !eq;    // >
  end

  always_comb begin
    hit = 1'b0;
    if (int'(cond) < NUM_COND) hit = flags[cond];
  end

endmodule

// File: rtl/branch_npc_target.sv
module branch_npc_target #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [15:0]     imm16,
  input  logic [25:0]     ofs26,
  output logic [XLEN-1:0] seq,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] ofs_tgt
);

  localparam int IMM_PAD = XLEN - 18;
  localparam int OFS_PAD = XLEN - 28;

  logic [XLEN-1:0] imm_scaled, ofs_scaled;

  assign imm_scaled = {{IMM_PAD{imm16[15]}}, imm16, 2'b00};
  assign ofs_scaled = {{OFS_PAD{ofs26[25]}}, ofs26, 2'b00};

  assign seq     = pc + XLEN'(4);
  assign br_tgt  = seq + imm_scaled;
  assign ofs_tgt = seq + ofs_scaled;

endmodule

// File: rtl/branch_npc.sv
module branch_npc
  import branch_npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              LINK_REG = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            exc_take,
  input  logic [XLEN-1:0] exc_vector,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic [4:0]      link_idx,
  output logic [XLEN-1:0] link_data
);

  ctl_t            ctl;
  logic            taken;
  logic [XLEN-1:0] seq, br_tgt, ofs_tgt, opa_snap, flow_pc;

  branch_npc_decode u_dec (
    .opcode (instr[31:26]),
    .ctl    (ctl)
  );

  branch_npc_cond #(.XLEN(XLEN)) u_cond (
    .a    (opa),
    .b    (opb),
    .cond (ctl.cond),
    .hit  (taken)
  );

  branch_npc_target #(.XLEN(XLEN)) u_tgt (
    .pc      (pc_q),
    .imm16   (instr[15:0]),
    .ofs26   (instr[25:0]),
    .seq     (seq),
    .br_tgt  (br_tgt),
    .ofs_tgt (ofs_tgt)
  );

  // Register target is taken from the operand as read this cycle,
  // before the link write lands at the edge.
  assign opa_snap = opa;

  always_comb begin
    case (ctl.src)
      SRC_BR:  flow_pc = (ctl.is_branch && taken) ? br_tgt : seq;
      SRC_OFS: flow_pc = ofs_tgt;
      SRC_REG: flow_pc = opa_snap;
      default: flow_pc = seq;
    endcase
  end

  assign next_pc   = exc_take ? exc_vector : flow_pc;
  assign link_we   = advance && ctl.link && !exc_take;
  assign link_idx  = 5'(LINK_REG);
  assign link_data = seq;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= RESET_PC;
    else if (advance) pc_q <= next_pc;
  end

endmodule

// File: rtl/branch_npc_chk.sv
module branch_npc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            advance,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] opa,
  input logic            exc_take,
  input logic [XLEN-1:0] exc_vector,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] next_pc,
  input logic            link_we
);

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc_q));

  // R11
  exc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && exc_take) |=> pc_q == $past(exc_vector));

  // R11
  exc_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> !link_we);

  // R12
  link_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |-> !link_we);

  // R8
  reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_take && (instr[31:26] == 6'h2B || instr[31:26] == 6'h2D))
      |-> next_pc == opa);

  // R9
  link_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !exc_take && (instr[31:26] == 6'h2C || instr[31:26] == 6'h2D))
      |-> link_we);

  // R4
  seq_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] < 6'h20 || instr[31:26] > 6'h2D) |-> !link_we);

endmodule

bind branch_npc branch_npc_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .advance    (advance),
  .instr      (instr),
  .opa        (opa),
  .exc_take   (exc_take),
  .exc_vector (exc_vector),
  .pc_q       (pc_q),
  .next_pc    (next_pc),
  .link_we    (link_we)
);

// File: tb/branch_npc_bench.sv
module branch_npc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 1'b0;
  logic [31:0] instr = '0, opa = '0, opb = '0, exc_vector = '0;
  logic        exc_take = 1'b0;
  logic [31:0] pc_q, next_pc, link_data;
  logic        link_we;
  logic [4:0]  link_idx;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model_pc = 32'h0;

  always #2.5 clk = ~clk;

  branch_npc u_branch_npc (
    .clk, .rst_n, .advance, .instr, .opa, .opb, .exc_take, .exc_vector,
    .pc_q, .next_pc, .link_we, .link_idx, .link_data
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (instr %h)", req, act, exp, instr);
    end
  endtask

  function automatic logic cond_ok(logic [5:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      6'h20: return a == b;
      6'h21: return a != b;
      6'h22: return $signed(a) <= $signed(b);
      6'h23: return a <= b;
      6'h24: return $signed(a) < $signed(b);
      6'h25: return a < b;
      6'h26: return $signed(a) >= $signed(b);
      6'h27: return a >= b;
      6'h28: return $signed(a) > $signed(b);
      default: return a > b;
    endcase
  endfunction

  function automatic logic [31:0] ref_next(logic [31:0] pc, logic [31:0] iw,
      logic [31:0] a, logic [31:0] b, logic ex, logic [31:0] vec);
    logic [5:0]  op = iw[31:26];
    logic [31:0] s  = pc + 32'd4;
    if (ex) return vec;
    if (op >= 6'h20 && op <= 6'h29)
      return cond_ok(op, a, b) ? s + {{14{iw[15]}}, iw[15:0], 2'b00} : s;
    if (op == 6'h2A || op == 6'h2C) return s + {{4{iw[25]}}, iw[25:0], 2'b00};
    if (op == 6'h2B || op == 6'h2D) return a;
    return s;
  endfunction

  function automatic logic ref_link(logic [5:0] op, logic adv, logic ex);
    return adv && !ex && (op == 6'h2C || op == 6'h2D);
  endfunction

  task automatic step(string req, logic [31:0] iw, logic [31:0] a, logic [31:0] b,
      logic ex, logic [31:0] vec, logic adv);
    logic [31:0] exp_n;
    logic        exp_l;
    @(negedge clk);
    instr = iw; opa = a; opb = b; exc_take = ex; exc_vector = vec; advance = adv;
    #1;
    exp_n = ref_next(model_pc, iw, a, b, ex, vec);
    exp_l = ref_link(iw[31:26], adv, ex);
    check(req, next_pc, exp_n);
    check({req, " link_we R9 R12"}, {31'd0, link_we}, {31'd0, exp_l});
    if (exp_l) begin
      check("R9 link_data", link_data, model_pc + 32'd4);
      check("R9 link_idx", {27'd0, link_idx}, 32'd31);
    end
    @(posedge clk);
    #1;
    if (adv) model_pc = exp_n;
    check("R3 pc_q", pc_q, model_pc);
  endtask

  function automatic logic [31:0] mk(logic [5:0] op, logic [25:0] rest);
    return {op, rest};
  endfunction

  initial begin : watchdog
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset pc", pc_q, 32'h0);
    check("R2 link_we idle", {31'd0, link_we}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R4 sequential
    step("R4 seq", mk(6'h00, 26'h123), 32'd1, 32'd2, 0, 0, 1);
    step("R4 seq hi", mk(6'h3F, 26'h3FFFFFF), 32'd1, 32'd2, 0, 0, 1);
    // R3 hold
    step("R3 hold", mk(6'h2A, 26'h10), 0, 0, 0, 0, 0);
    // R5 R6 boundaries: signed vs unsigned
    step("R6 blt signed", mk(6'h24, 26'h0000_008), 32'h8000_0000, 32'h1, 0, 0, 1);
    step("R6 bltu unsigned", mk(6'h25, 26'h0000_008), 32'h8000_0000, 32'h1, 0, 0, 1);
    step("R6 bge eq", mk(6'h26, 26'h000FFFC), 32'h7, 32'h7, 0, 0, 1);
    step("R6 bgt eq", mk(6'h28, 26'h0000010), 32'h7, 32'h7, 0, 0, 1);
    step("R6 bleu eq", mk(6'h23, 26'h0000010), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1);
    step("R6 bgtu max", mk(6'h29, 26'h0008000), 32'hFFFF_FFFF, 32'h0, 0, 0, 1);
    step("R5 beq neg imm", mk(6'h20, 26'h0008000), 32'h5, 32'h5, 0, 0, 1);
    step("R5 bne not taken", mk(6'h21, 26'h0007FFF), 32'h5, 32'h5, 0, 0, 1);
    // R7 offsets
    step("R7 j neg", mk(6'h2A, 26'h2000000), 0, 0, 0, 0, 1);
    step("R7 j pos", mk(6'h2A, 26'h1FFFFFF), 0, 0, 0, 0, 1);
    step("R7 jal", mk(6'h2C, 26'h0000040), 0, 0, 0, 0, 1);
    // R8 unchanged low bits
    step("R8 jr odd", mk(6'h2B, 26'h0), 32'h1234_5677, 0, 0, 0, 1);
    // R10 jalr naming r31 (bits 25:21 = 31)
    step("R10 jalr r31", mk(6'h2D, {5'd31, 21'd0}), 32'h0000_4000, 0, 0, 0, 1);
    // R11 override
    step("R11 exc jal", mk(6'h2C, 26'h40), 0, 0, 1, 32'hC000_0004, 1);
    step("R11 exc no adv", mk(6'h20, 26'h4), 1, 1, 1, 32'hC000_0008, 0);
    // R12
    step("R12 jalr no adv", mk(6'h2D, 26'h0), 32'h80, 0, 0, 0, 0);
    // R1 field placement random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0]  op;
      logic [31:0] a, b;
      int sel = $urandom_range(0, 9);
      op = (sel < 6) ? 6'(6'h20 + $urandom_range(0, 13)) : 6'($urandom);
      a = $urandom;
      case ($urandom_range(0, 3))
        0: b = a;
        1: b = a ^ 32'h8000_0000;
        2: b = a + 32'd1;
        default: b = $urandom;
      endcase
      step("R1 R5 R6 R7 random", {op, 26'($urandom)}, a, b,
           ($urandom_range(0, 15) == 0), $urandom, ($urandom_range(0, 7) != 0));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule